// File: doc/BRIEF.md
# DTMF Key Status and Interrupt Controller

This block connects a dual-tone detection front end to a host's register bus. The front end reports whether a tone pair is present, which of the four low-group frequencies it contains (697, 770, 852 or 941 Hz) and which of the four high-group frequencies it contains (1209, 1336, 1477 or 1633 Hz). The block turns each pair into a 4-bit key code and stores it in a receive register. It tracks whether a tone is present and flags a change event each time a tone starts or stops. A maskable interrupt reports these events to the host.

The host reaches four 8-bit registers over a synchronous port with one-cycle read latency. A control register holds the enable bit and a mask register holds the interrupt mask bit. A status register carries the tone-present and change-event flags, and reading it clears the event. The last register holds the key code. Clearing the enable bit silences the block and zeroes its status and key code.

Top module: `dtmf_status_ctrl`

## Requirements
- R1: After a synchronous reset every register reads 0x00, `irq_o` is 0 and `rdata_o` is 0x00.
- R2: Address 0 is the control register and address 1 is the mask register. Both are 8 bits wide, read and write. Address 2 (status) and address 3 (key code) are read-only, and writes to them are ignored. `rdata_o` carries the addressed register in the cycle after `rd_en_i` is sampled.
- R3: While enabled, a 0-to-1 transition of `tone_valid_i` sets status bit 4 (tone present) and status bit 5 (change event) in the cycle after the first high sample. In the same cycle the key register is loaded with the code of the pair sampled on that clock edge.
- R4: While enabled, a 1-to-0 transition of `tone_valid_i` sets status bit 5 and clears status bit 4 on the same clock edge.
- R5: `irq_o` equals status bit 5 ANDed with mask register bit 5 while enabled, and it follows a mask change by one cycle. With mask bit 5 at 0, `irq_o` stays 0.
- R6: Index encoding: `low_idx_i` 0..3 selects 697/770/852/941 Hz and `high_idx_i` 0..3 selects 1209/1336/1477/1633 Hz. Rows 697, 770 and 852 with columns 1209, 1336 and 1477 give codes 1..9 in reading order. The 941 Hz row gives 11 (\*), 10 (0), 12 (#) and 0 (D). The 1633 Hz column gives 13 (A), 14 (B) and 15 (C) for the first three rows.
- R7: The key register keeps its last code after the tone is lost, until the next onset or until the block is disabled.
- R8: A status read clears status bit 5 and drops `irq_o`. If a tone transition falls in the same cycle as the read, the event is set and the read returns the value the status held before that edge.
- R9: With control bit 5 at 0, status bits 4 and 5, the key code and `irq_o` are 0 from the next cycle on. Enabling the block while a tone is present produces an onset event.
- R10: A tone held steady produces exactly one event. After that event is cleared, status bit 5 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_valid_i | input | 1 | Front end reports a tone pair present |
| low_idx_i | input | 2 | Low-group frequency index |
| high_idx_i | input | 2 | High-group frequency index |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench steps through all sixteen tone pairs, so a swapped row or column, or a wrong code for the 941 Hz row or the 1633 Hz column, shows up as a bad key readout. It makes a status read coincide with a tone drop. A design that let the read win would lose that event and the interrupt with it. It unmasks the interrupt while an event is pending and expects `irq_o` to rise; a design that raised the interrupt only on the event edge would stay quiet. It also disables and then re-enables the block with a tone held. A design that kept its edge history across the disable would miss the onset or would keep a stale code.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  localparam int REG_AW = 2;
  localparam int IDX_W  = 2;
  localparam int CODE_W = 4;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL   = 2'd0,
    REG_MASK   = 2'd1,
    REG_STATUS = 2'd2,
    REG_KEY    = 2'd3
  } reg_addr_e;

  localparam int NUM_RW = 2;  // control and mask are the writable registers
endpackage

// File: rtl/dtmf_key_encoder.sv
module dtmf_key_encoder
  import dtmf_pkg::*;
(
  input  logic [IDX_W-1:0]  low_idx_i,
  input  logic [IDX_W-1:0]  high_idx_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [IDX_W-1:0] LAST = '1;

  always_comb begin
    if (high_idx_i == LAST) begin
      // right-hand letter column; bottom row of it is D = 0
      code_o = (low_idx_i == LAST) ? '0 : CODE_W'(13) + CODE_W'(low_idx_i);
    end else if (low_idx_i == LAST) begin
      unique case (high_idx_i)
        2'd0:    code_o = CODE_W'(11);
        2'd1:    code_o = CODE_W'(10);
        default: code_o = CODE_W'(12);
      endcase
    end else begin
      code_o = CODE_W'(low_idx_i) * CODE_W'(3) + CODE_W'(high_idx_i) + CODE_W'(1);
    end
  end
endmodule

// File: rtl/dtmf_tone_edge.sv
module dtmf_tone_edge (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic tone_i,
  output logic prev_o,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  // history is forced low while disabled so a re-enable sees a fresh onset
  always_ff @(posedge clk) begin
    if (rst)        prev_q <= 1'b0;
    else if (en_i)  prev_q <= tone_i;
    else            prev_q <= 1'b0;
  end

  assign prev_o = prev_q;
  assign rise_o = tone_i & ~prev_q;
  assign fall_o = ~tone_i & prev_q;
endmodule

// File: rtl/dtmf_host_regs.sv
module dtmf_host_regs
  import dtmf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] mask_o
);
  logic [NUM_RW-1:0][DATA_W-1:0] regs_q;

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    always_ff @(posedge clk) begin
      if (rst)                                         regs_q[g] <= '0;
      else if (wr_en_i && addr_i == REG_AW'(g))        regs_q[g] <= wdata_i;
    end
  end

  assign ctrl_o = regs_q[REG_CTRL];
  assign mask_o = regs_q[REG_MASK];
endmodule

// File: rtl/dtmf_status_ctrl.sv
module dtmf_status_ctrl
  import dtmf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int EN_BIT   = 5,
  parameter int EVT_BIT  = 5,
  parameter int TONE_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tone_valid_i,
  input  logic [IDX_W-1:0]  low_idx_i,
  input  logic [IDX_W-1:0]  high_idx_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] ctrl_q, mask_q;
  logic              en_q, mask_on;
  logic              prev_q, rise, fall;
  logic [CODE_W-1:0] code;
  logic              evt_q, pres_q;
  logic [CODE_W-1:0] rx_q;
  logic              evt_n, pres_n, irq_n;
  logic [CODE_W-1:0] rx_n;
  logic              onset, loss, rd_stat;
  logic [DATA_W-1:0] status_v, rd_mux;

  dtmf_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ctrl_o(ctrl_q), .mask_o(mask_q)
  );

  assign en_q    = ctrl_q[EN_BIT];
  assign mask_on = mask_q[EVT_BIT];

  dtmf_tone_edge u_edge (
    .clk(clk), .rst(rst), .en_i(en_q), .tone_i(tone_valid_i),
    .prev_o(prev_q), .rise_o(rise), .fall_o(fall)
  );

  dtmf_key_encoder u_enc (
    .low_idx_i(low_idx_i), .high_idx_i(high_idx_i), .code_o(code)
  );

  assign onset   = en_q & rise;
  assign loss    = en_q & fall;
  assign rd_stat = rd_en_i && (addr_i == REG_STATUS);

  always_comb begin
    if (!en_q) begin
      evt_n  = 1'b0;
      pres_n = 1'b0;
      rx_n   = '0;
    end else begin
      // a fresh transition outranks a clearing read
      if (onset || loss)  evt_n = 1'b1;
      else if (rd_stat)   evt_n = 1'b0;
      else                evt_n = evt_q;
      if (onset)          pres_n = 1'b1;
      else if (loss)      pres_n = 1'b0;
      else                pres_n = pres_q;
      rx_n = onset ? code : rx_q;
    end
    irq_n = en_q & mask_on & evt_n;
  end

  always_comb begin
    status_v           = '0;
    status_v[EVT_BIT]  = evt_q;
    status_v[TONE_BIT] = pres_q;
    unique case (addr_i)
      REG_CTRL:   rd_mux = ctrl_q;
      REG_MASK:   rd_mux = mask_q;
      REG_STATUS: rd_mux = status_v;
      default:    rd_mux = DATA_W'(rx_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q   <= 1'b0;
      pres_q  <= 1'b0;
      rx_q    <= '0;
      irq_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      evt_q  <= evt_n;
      pres_q <= pres_n;
      rx_q   <= rx_n;
      irq_o  <= irq_n;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/dtmf_status_ctrl_chk.sv
module dtmf_status_ctrl_chk
  import dtmf_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              en_q,
  input logic              mask_on,
  input logic              rise,
  input logic              fall,
  input logic              rd_stat,
  input logic              evt_q,
  input logic              pres_q,
  input logic [CODE_W-1:0] rx_q,
  input logic [CODE_W-1:0] code,
  input logic              irq_o
);
  p_onset_r3: assert property (@(posedge clk) disable iff (rst)
    (en_q && rise) |=> (evt_q && pres_q && rx_q == $past(code)));

  p_loss_r4: assert property (@(posedge clk) disable iff (rst)
    (en_q && fall) |=> (evt_q && !pres_q));

  p_irq_needs_event_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> evt_q);

  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !mask_on |=> !irq_o);

  p_key_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (en_q && !rise) |=> (rx_q == $past(rx_q)));

  p_read_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (en_q && rd_stat && !rise && !fall) |=> !evt_q);

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (!irq_o && !evt_q && !pres_q && rx_q == '0));
endmodule

bind dtmf_status_ctrl dtmf_status_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .mask_on(mask_on), .rise(rise),
  .fall(fall), .rd_stat(rd_stat), .evt_q(evt_q), .pres_q(pres_q),
  .rx_q(rx_q), .code(code), .irq_o(irq_o)
);

// File: tb/dtmf_status_ctrl_tb.sv
module dtmf_status_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tone_valid_i = 1'b0;
  logic [1:0] low_idx_i = '0, high_idx_i = '0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  dtmf_status_ctrl u_dut (
    .clk(clk), .rst(rst), .tone_valid_i(tone_valid_i), .low_idx_i(low_idx_i),
    .high_idx_i(high_idx_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [3:0] exp_code(input logic [1:0] lo, input logic [1:0] hi);
    case ({lo, hi})
      4'b00_00: return 4'd1;  4'b00_01: return 4'd2;
      4'b00_10: return 4'd3;  4'b00_11: return 4'd13;
      4'b01_00: return 4'd4;  4'b01_01: return 4'd5;
      4'b01_10: return 4'd6;  4'b01_11: return 4'd14;
      4'b10_00: return 4'd7;  4'b10_01: return 4'd8;
      4'b10_10: return 4'd9;  4'b10_11: return 4'd15;
      4'b11_00: return 4'd11; 4'b11_01: return 4'd10;
      4'b11_10: return 4'd12; default:  return 4'd0;
    endcase
  endfunction

  // monitor: compares read data in the cycle after the read is sampled
  always @(posedge clk) rd_seen <= rd_en_i;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (rdata_o !== e) begin
        n_bad++;
        $display("FAIL %s: rdata actual 0x%02h expected 0x%02h", t, rdata_o, e);
      end
    end
  end

  task automatic chk_irq(input logic e, input string t);
    n_cmp++;
    if (irq_o !== e) begin
      n_bad++;
      $display("FAIL %s: irq actual %0b expected %0b", t, irq_o, e);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); rd_en_i = 1'b1; addr_i = a;
    @(negedge clk); rd_en_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic tone(input logic v, input logic [1:0] lo, input logic [1:0] hi);
    @(negedge clk); tone_valid_i = v; low_idx_i = lo; high_idx_i = hi;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(2'd0, 8'h00, "R1 ctrl reset");
    rd(2'd1, 8'h00, "R1 mask reset");
    rd(2'd2, 8'h00, "R1 status reset");
    rd(2'd3, 8'h00, "R1 key reset");
    // R2 register map
    wr(2'd0, 8'hA5);
    rd(2'd0, 8'hA5, "R2 ctrl readback");
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h20);
    rd(2'd1, 8'h20, "R2 mask readback");
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd2, 8'h00, "R2 status write ignored");
    rd(2'd3, 8'h00, "R2 key write ignored");
    // R3, R4, R5, R6, R7 across every tone pair
    for (int lo = 0; lo < 4; lo++) begin
      for (int hi = 0; hi < 4; hi++) begin
        logic [3:0] c;
        c = exp_code(2'(lo), 2'(hi));
        tone(1'b1, 2'(lo), 2'(hi));
        chk_irq(1'b1, "R5 irq on onset");
        rd(2'd3, {4'h0, c}, "R6 key code");
        rd(2'd2, 8'h30, "R3 onset status");
        chk_irq(1'b0, "R8 irq cleared by read");
        tone(1'b0, 2'(lo ^ 1), 2'(hi ^ 2));
        chk_irq(1'b1, "R5 irq on loss");
        rd(2'd2, 8'h20, "R4 loss status");
        rd(2'd3, {4'h0, c}, "R7 key held after loss");
      end
    end
    // R10 held tone gives one event
    tone(1'b1, 2'd0, 2'd0);
    rd(2'd2, 8'h30, "R10 first event");
    repeat (10) @(negedge clk);
    rd(2'd2, 8'h10, "R10 no repeat event");
    chk_irq(1'b0, "R10 irq stays low");
    // R8 read coinciding with a tone drop
    exp_q.push_back(8'h10);
    tag_q.push_back("R8 read sees pre-edge status");
    @(negedge clk); rd_en_i = 1'b1; addr_i = 2'd2; tone_valid_i = 1'b0;
    @(negedge clk); rd_en_i = 1'b0;
    chk_irq(1'b1, "R8 event wins over read");
    rd(2'd2, 8'h20, "R8 event kept");
    // R5 masking and late unmask
    wr(2'd1, 8'h00);
    tone(1'b1, 2'd1, 2'd2);
    chk_irq(1'b0, "R5 masked irq");
    wr(2'd1, 8'h20);
    chk_irq(1'b1, "R5 unmask with pending event");
    wr(2'd1, 8'h00);
    chk_irq(1'b0, "R5 remask drops irq");
    rd(2'd2, 8'h30, "R5 status while masked");
    // R9 disable with tone held, then re-enable
    wr(2'd1, 8'h20);
    wr(2'd0, 8'h00);
    chk_irq(1'b0, "R9 irq off when disabled");
    rd(2'd2, 8'h00, "R9 status forced low");
    rd(2'd3, 8'h00, "R9 key forced low");
    wr(2'd0, 8'h20);
    @(negedge clk);
    chk_irq(1'b1, "R9 onset after re-enable");
    rd(2'd2, 8'h30, "R9 status after re-enable");
    rd(2'd3, 8'h06, "R9 key after re-enable");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule